// File: doc/BRIEF.md
# Max-Min Fair Rate Allocator

This block divides one link capacity among a fixed set of flows using the max-min (water-filling) rule. A host loads the capacity and one requested rate per flow through a write port. It then pulses `start`. The engine works in rounds. In each round it finds the flow with the smallest request among those not yet served. It grants that flow either the whole request or the current equal share, whichever is smaller. The equal share is the remaining capacity divided by the number of flows still waiting. The grant is then taken off the remaining capacity and one flow is removed from the count. The next round uses the reduced values.

Rates are unsigned fixed point with 8 fractional bits, so 1.0 is coded as 256. The minimum search is a linear scan that looks at one flow per clock, and each flow carries an allocated flag. The equal share comes from a restoring divider that produces one quotient bit per clock, and the quotient is truncated. When every flow has been served, `done` rises and stays high. The allocations are then read through a combinational read port indexed by flow number.

Top module: `maxmin_alloc`

## Requirements
- R1: After reset `busy` and `done` are 0 and every flow allocation reads 0.
- R2: Each round serves the unallocated flow with the smallest request. When requests are equal, the lowest flow index is served first.
- R3: A served flow whose request is less than or equal to the current share is granted exactly its request.
- R4: A served flow whose request exceeds the current share is granted the share, which is floor(remaining capacity / remaining flow count). It is recomputed every round after the previous grant has been subtracted.
- R5: After the last round `done` is 1 and `busy` is 0. Every flow has been served exactly once, and the sum of the allocations never exceeds the capacity.
- R6: Rates carry 8 fractional bits. With capacity 256 and requests 25, 128, 2560 and 1280, the allocations are 25, 77, 77 and 77.
- R7: While `busy` is 1, `start` has no effect, and writes to the capacity or the requests are discarded.
- R8: `done` stays 1 until the next accepted `start`, which clears it. A new run recomputes the allocations from the stored capacity and requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for capacity or request |
| wrCap | input | 1 | 1: write the capacity, 0: write the request of flow `wrIdx` |
| wrIdx | input | IDX_W (2) | Flow index for a request write |
| wrData | input | RATE_W (16) | Rate value, 8 fractional bits |
| start | input | 1 | Pulse to begin an allocation run |
| rdIdx | input | IDX_W (2) | Flow index for reading an allocation |
| rdData | output | RATE_W (16) | Allocation of flow `rdIdx` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished; allocations valid |

## Verification
The hardest case to reach from the ports is a run where the order of service matters. This happens when tied requests meet a truncated share, so the leftover units from truncation go to the later flows. A vector with capacity 10 and four requests of 100 drives this case and must give 2, 2, 3 and 3. The other hard case is a host that writes or restarts in the middle of a run. The bench changes a request and pulses `start` while the scan is running, then starts a second run without rewriting anything. It checks that both runs give the allocations of the original values.

// File: rtl/mmf_pkg.sv
package mmf_pkg;
  typedef struct packed {
    logic load;
    logic scanInit;
    logic scanStep;
    logic divGo;
    logic grant;
  } mmfStrobe_t;
endpackage

// File: rtl/mmf_div.sv
module mmf_div #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quot,
  output logic             fin
);
  localparam int STEP_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;

  logic [DEN_W-1:0]  acc;
  logic [NUM_W-1:0]  qReg;
  logic [DEN_W-1:0]  denL;
  logic [NUM_W-1:0]  numL;
  logic [STEP_W-1:0] stepCnt;
  logic              running;
  logic [DEN_W:0]    shifted;
  logic [DEN_W:0]    diff;
  logic              fits;

  assign shifted = {acc, qReg[NUM_W-1]};
  assign fits    = shifted >= {1'b0, denL};
  assign diff    = shifted - {1'b0, denL};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      qReg    <= '0;
      denL    <= '0;
      numL    <= '0;
      stepCnt <= '0;
      running <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc     <= '0;
        qReg    <= num;
        numL    <= num;
        denL    <= den;
        stepCnt <= '0;
        running <= 1'b1;
      end else if (running) begin
        if (fits) begin
          acc  <= diff[DEN_W-1:0];
          qReg <= {qReg[NUM_W-2:0], 1'b1};
        end else begin
          acc  <= shifted[DEN_W-1:0];
          qReg <= {qReg[NUM_W-2:0], 1'b0};
        end
        stepCnt <= stepCnt + 1'b1;
        if (stepCnt == STEP_W'(NUM_W - 1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end
    end
  end

  assign quot = qReg;

  logic [NUM_W+DEN_W-1:0] prod;
  logic [NUM_W+DEN_W-1:0] numExt;
  logic [NUM_W+DEN_W-1:0] denExt;
  assign prod   = {{DEN_W{1'b0}}, qReg} * {{NUM_W{1'b0}}, denL};
  assign numExt = {{DEN_W{1'b0}}, numL};
  assign denExt = {{NUM_W{1'b0}}, denL};

  // R4
  quot_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (prod <= numExt) && ((numExt - prod) < denExt));
endmodule

// File: rtl/mmf_ctrl.sv
module mmf_ctrl
  import mmf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       scanLast,
  input  logic       divFin,
  input  logic       lastFlow,
  output mmfStrobe_t stb,
  output logic       busy,
  output logic       done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_DIVGO, ST_WAIT, ST_GRANT
  } ctrlState_t;

  ctrlState_t state, nextState;

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (start) begin
        stb.load     = 1'b1;
        stb.scanInit = 1'b1;
        nextState    = ST_SCAN;
      end
      ST_SCAN: begin
        stb.scanStep = 1'b1;
        if (scanLast) nextState = ST_DIVGO;
      end
      ST_DIVGO: begin
        stb.divGo = 1'b1;
        nextState = ST_WAIT;
      end
      ST_WAIT: if (divFin) nextState = ST_GRANT;
      ST_GRANT: begin
        stb.grant = 1'b1;
        if (lastFlow) nextState = ST_IDLE;
        else begin
          stb.scanInit = 1'b1;
          nextState    = ST_SCAN;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) done <= 1'b0;
      else if (state == ST_GRANT && lastFlow) done <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

  // R5
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCAN) && start |=> busy);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(start));
endmodule

// File: rtl/mmf_dpath.sv
module mmf_dpath
  import mmf_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int RATE_W    = 16,
  localparam int IDX_W    = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1,
  localparam int CNT_W    = $clog2(NUM_FLOWS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mmfStrobe_t        stb,
  input  logic              busy,
  input  logic              wrEn,
  input  logic              wrCap,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [RATE_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [RATE_W-1:0] rdData,
  output logic              scanLast,
  output logic              divFin,
  output logic              lastFlow
);
  logic [RATE_W-1:0]    reqMem   [NUM_FLOWS];
  logic [RATE_W-1:0]    allocMem [NUM_FLOWS];
  logic [NUM_FLOWS-1:0] allocFlag;
  logic [RATE_W-1:0]    capReg;
  logic [RATE_W-1:0]    remCap;
  logic [CNT_W-1:0]     remCnt;
  logic [IDX_W-1:0]     scanIdx;
  logic [IDX_W-1:0]     minIdx;
  logic [RATE_W-1:0]    minReq;
  logic                 minValid;
  logic [RATE_W-1:0]    share;
  logic [RATE_W-1:0]    grantVal;
  logic [RATE_W-1:0]    scanReq;
  logic                 scanTake;
  logic                 hostWr;

  assign hostWr = wrEn && !busy;

  // capacity register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) capReg <= '0;
    else if (hostWr && wrCap) capReg <= wrData;
  end

  // per-flow request, allocation and flag
  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow
    logic hit;
    assign hit = (minIdx == IDX_W'(f));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reqMem[f] <= '0;
      else if (hostWr && !wrCap && wrIdx == IDX_W'(f)) reqMem[f] <= wrData;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        allocMem[f]  <= '0;
        allocFlag[f] <= 1'b0;
      end else if (stb.load) begin
        allocMem[f]  <= '0;
        allocFlag[f] <= 1'b0;
      end else if (stb.grant && hit) begin
        allocMem[f]  <= grantVal;
        allocFlag[f] <= 1'b1;
      end
    end
  end

  // linear minimum scan
  assign scanReq  = reqMem[scanIdx];
  assign scanTake = !allocFlag[scanIdx] && (!minValid || scanReq < minReq);
  assign scanLast = (scanIdx == IDX_W'(NUM_FLOWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scanIdx  <= '0;
      minIdx   <= '0;
      minReq   <= '0;
      minValid <= 1'b0;
    end else if (stb.scanInit) begin
      scanIdx  <= '0;
      minValid <= 1'b0;
    end else if (stb.scanStep) begin
      scanIdx <= scanIdx + 1'b1;
      if (scanTake) begin
        minIdx   <= scanIdx;
        minReq   <= scanReq;
        minValid <= 1'b1;
      end
    end
  end

  // share divider
  mmf_div #(.NUM_W(RATE_W), .DEN_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (stb.divGo),
    .num   (remCap),
    .den   (remCnt),
    .quot  (share),
    .fin   (divFin)
  );

  // grant and remaining resources
  assign grantVal = (minReq <= share) ? minReq : share;
  assign lastFlow = (remCnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remCap <= '0;
      remCnt <= '0;
    end else if (stb.load) begin
      remCap <= capReg;
      remCnt <= CNT_W'(NUM_FLOWS);
    end else if (stb.grant) begin
      remCap <= remCap - grantVal;
      remCnt <= remCnt - 1'b1;
    end
  end

  assign rdData = allocMem[rdIdx];

  // R2
  min_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.divGo |-> minValid && !allocFlag[minIdx]);

  // R5
  grant_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.grant |-> grantVal <= remCap);

  // R5
  cap_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !stb.load |=> remCap <= $past(remCap));

  // R4
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.divGo |-> remCnt != '0);
endmodule

// File: rtl/maxmin_alloc.sv
module maxmin_alloc
  import mmf_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int RATE_W    = 16,
  localparam int IDX_W    = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrCap,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [RATE_W-1:0] wrData,
  input  logic              start,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [RATE_W-1:0] rdData,
  output logic              busy,
  output logic              done
);
  mmfStrobe_t stb;
  logic scanLast, divFin, lastFlow;

  mmf_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .scanLast (scanLast),
    .divFin   (divFin),
    .lastFlow (lastFlow),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  mmf_dpath #(.NUM_FLOWS(NUM_FLOWS), .RATE_W(RATE_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .busy     (busy),
    .wrEn     (wrEn),
    .wrCap    (wrCap),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .rdIdx    (rdIdx),
    .rdData   (rdData),
    .scanLast (scanLast),
    .divFin   (divFin),
    .lastFlow (lastFlow)
  );
endmodule

// File: tb/sim_maxmin_alloc.sv
module sim_maxmin_alloc;
  localparam int NF = 4;
  localparam int RW = 16;
  localparam int NCASE = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic          wrCap = 1'b0;
  logic [1:0]    wrIdx = '0;
  logic [RW-1:0] wrData = '0;
  logic          start = 1'b0;
  logic [1:0]    rdIdx = '0;
  logic [RW-1:0] rdData;
  logic          busy, done;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  maxmin_alloc #(.NUM_FLOWS(NF), .RATE_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrCap(wrCap), .wrIdx(wrIdx),
    .wrData(wrData), .start(start), .rdIdx(rdIdx), .rdData(rdData),
    .busy(busy), .done(done)
  );

  // cap, req0..req3, exp0..exp3, requirement number
  localparam int VEC [NCASE][10] = '{
    '{256,   25, 128, 2560, 1280,  25, 77, 77, 77, 6},         // R6 worked example
    '{1000,  10, 20, 30, 40,       10, 20, 30, 40, 3},         // R3 all below share
    '{1000,  5000, 5000, 5000, 5000, 250, 250, 250, 250, 4},   // R4 all above share
    '{10,    100, 100, 100, 100,   2, 2, 3, 3, 2},             // R2 ties + R4 truncation
    '{400,   100, 300, 100, 100,   100, 100, 100, 100, 3},     // R3 equal to share
    '{900,   500, 50, 200, 700,    325, 50, 200, 325, 2},      // R2 unordered mix
    '{0,     5, 6, 7, 8,           0, 0, 0, 0, 4},             // R4 zero capacity
    '{300,   0, 0, 0, 0,           0, 0, 0, 0, 3},             // R3 zero requests
    '{65535, 65535, 65535, 65535, 65535, 16383, 16384, 16384, 16384, 4} // R4 full range
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic isCap, input int idx, input int val);
    @(negedge clk);
    wrEn = 1'b1; wrCap = isCap; wrIdx = idx[1:0]; wrData = val[RW-1:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " done reached"}, int'(done), 1);
  endtask

  task automatic readAlloc(input int idx, output int val);
    rdIdx = idx[1:0];
    #1;
    val = int'(rdData);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int v;
    int sum;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    for (int f = 0; f < NF; f++) begin
      readAlloc(f, v);
      chk("R1 alloc", v, 0);
    end

    // table-driven runs
    for (int c = 0; c < NCASE; c++) begin
      string tag;
      tag = $sformatf("R%0d case%0d", VEC[c][9], c);
      wr(1'b1, 0, VEC[c][0]);
      for (int f = 0; f < NF; f++) wr(1'b0, f, VEC[c][1+f]);
      pulseStart();
      waitDone(tag);
      @(negedge clk);
      chk({tag, " R5 busy low"}, int'(busy), 0);
      sum = 0;
      for (int f = 0; f < NF; f++) begin
        readAlloc(f, v);
        chk({tag, $sformatf(" alloc%0d", f)}, v, VEC[c][5+f]);
        sum += v;
      end
      chk({tag, " R5 sum within capacity"}, int'(sum <= VEC[c][0]), 1);
    end

    // R7: writes and start during a run are ignored
    wr(1'b1, 0, 256);
    wr(1'b0, 0, 25);  wr(1'b0, 1, 128);
    wr(1'b0, 2, 2560); wr(1'b0, 3, 1280);
    pulseStart();
    chk("R8 done cleared by start", int'(done), 0);
    chk("R7 busy after start", int'(busy), 1);
    wr(1'b0, 0, 999);
    wr(1'b1, 0, 5);
    pulseStart();
    chk("R7 still busy", int'(busy), 1);
    waitDone("R7");
    for (int f = 0; f < NF; f++) begin
      readAlloc(f, v);
      chk($sformatf("R7 alloc%0d", f), v, VEC[0][5+f]);
    end

    // R8: done held, rerun from stored values (proves the writes were dropped)
    repeat (5) @(negedge clk);
    chk("R8 done held", int'(done), 1);
    pulseStart();
    chk("R8 done cleared", int'(done), 0);
    waitDone("R8");
    for (int f = 0; f < NF; f++) begin
      readAlloc(f, v);
      chk($sformatf("R8 R7 rerun alloc%0d", f), v, VEC[0][5+f]);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule